// File: doc/BRIEF.md
# Framed Image Download Receiver

This block receives a framed binary image over a byte-wide serial link and checks it. A session starts when `start` is pulsed while the block is idle or finished. The block then sends a four-byte greeting out on the transmit byte port. Next it expects a 12-byte header: the same four bytes again, then a 32-bit byte count and a 32-bit expected checksum. Bytes that arrive while the greeting is still being sent are consumed and dropped.

After a valid header, exactly the announced number of payload bytes pass from the receive port to a valid/ready payload port. A running reflected CRC-32 is updated as each byte goes through. When the last byte has been taken, the computed checksum is compared with the header value, and the outcome is held on the status outputs until the next session. A bad greeting echo or a late header makes the block send the greeting again and retry on its own. A payload that stops arriving ends the session with a timeout. Both deadlines are counted in clock cycles, derived from the clock-frequency parameter.

Top module: `uart_image_loader`

## Requirements
- R1: On `start` from idle or finished, the bytes 0x46, 0x47, 0x50, 0x41 are offered in that order on `tx_data`/`tx_valid`. Each byte is held stable until `tx_ready` takes it.
- R2: Receive bytes that arrive before the last greeting byte has been taken are accepted (`rx_ready` high) and dropped. They never show on `pay_valid` and they do not count toward the header.
- R3: Header bytes 0..3 must equal 0x46, 0x47, 0x50, 0x41. If a received byte differs, `sync_retry` pulses for one cycle and the greeting is sent again from its first byte.
- R4: Header bytes 4..7 form the payload length and bytes 8..11 form the expected CRC. Both fields are taken least-significant byte first. Once the header completes they are shown on `pay_len` and `exp_crc`.
- R5: The header must be fully received within HDR_MS milliseconds of CLK_HZ cycles, counted from the edge that takes the last greeting byte. If it is not, `sync_retry` pulses and `tx_valid` rises, both exactly that many cycles after that edge, and the greeting is sent again.
- R6: Exactly `pay_len` payload bytes appear on `pay_data`/`pay_valid`, in order. `rx_ready` follows `pay_ready` during the payload, so no byte is lost while the sink stalls. Bytes received after the payload are not forwarded.
- R7: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF, final XOR 0xFFFFFFFF). For example, "123456789" gives 0xCBF43926. The result appears on `calc_crc`. A match sets `crc_ok` and a mismatch sets `crc_bad`, each together with `done`.
- R8: A length of zero skips the payload and gives a verdict with `calc_crc` = 0x00000000.
- R9: If the payload has not fully arrived within PAY_MS milliseconds of the edge that completed the header, `done` and `load_timeout` rise exactly that many cycles after that edge.
- R10: A last payload byte taken on the very edge where the payload deadline expires is accepted, and the CRC verdict is given. One cycle later, the timeout wins and the byte is dropped.
- R11: After reset, `tx_valid`, `done`, `crc_ok`, `crc_bad`, `load_timeout` and `sync_retry` are low. `done` and exactly one verdict flag stay set until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (idle or finished only) |
| tx_data | output | 8 | Greeting byte to the serial transmitter |
| tx_valid | output | 1 | Greeting byte offered |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_data | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Block takes the received byte |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | Payload byte offered |
| pay_ready | input | 1 | Payload sink takes the byte |
| done | output | 1 | Session finished with a verdict |
| crc_ok | output | 1 | Checksum matched |
| crc_bad | output | 1 | Checksum mismatched |
| load_timeout | output | 1 | Payload deadline expired |
| sync_retry | output | 1 | One-cycle pulse on header failure and greeting restart |
| pay_len | output | 32 | Payload length from the header |
| exp_crc | output | 32 | Expected CRC from the header |
| calc_crc | output | 32 | Computed CRC |

## Verification
The acceptance of the final payload byte and the expiry of the payload deadline can fall in the same cycle. The bench counts clock edges from the edge that completed the header. It offers the last byte so that it is taken exactly on the deadline edge, and expects a CRC verdict with no timeout. It then repeats the session with the byte one cycle later, and expects `load_timeout` with that byte absent from the payload port. The header deadline is checked in the same way: `tx_valid` must still be low one cycle before the limit and high on the limit.

// File: rtl/img_loader_pkg.sv
package img_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_HDR,
    ST_PAY,
    ST_CHECK,
    ST_DONE
  } ld_state_e;

  localparam int          MAGIC_BYTES = 4;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOROUT  = 32'hFFFF_FFFF;

  // Greeting byte sequence; the order is part of the link protocol.
  function automatic logic [7:0] magic_at(input logic [1:0] i);
    logic [7:0] b;
    case (i)
      2'd0:    b = 8'h46;
      2'd1:    b = 8'h47;
      2'd2:    b = 8'h50;
      default: b = 8'h41;
    endcase
    return b;
  endfunction

  // One byte of reflected CRC-32, unrolled over eight bit steps.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/img_crc32.sv
module img_crc32
  import img_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] result
);

  logic [31:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= CRC_SEED;
    end else if (en) begin
      acc <= crc_step(acc, data);
    end
  end

  assign result = acc ^ CRC_XOROUT;

endmodule

// File: rtl/img_phase_timer.sv
module img_phase_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] limit,
  input  logic          run,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= limit - CW'(1);
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - CW'(1);
    end
  end

  // Expiry is reported in the last cycle of the window.
  assign expired = run && !load && (cnt == '0);

endmodule

// File: rtl/img_hdr_collect.sv
module img_hdr_collect
  import img_loader_pkg::*;
#(
  parameter int FIELD_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               en,
  input  logic [7:0]         data,
  output logic               magic_bad,
  output logic               complete,
  output logic [FIELD_W-1:0] field_len,
  output logic [FIELD_W-1:0] field_crc
);

  localparam int FB     = FIELD_W / 8;
  localparam int NBYTES = MAGIC_BYTES + 2 * FB;
  localparam int IW     = $clog2(NBYTES + 1);

  logic [IW-1:0] idx;
  logic          in_magic;
  logic          in_len;
  logic          in_crc;

  assign in_magic  = int'(idx) < MAGIC_BYTES;
  assign in_len    = !in_magic && (int'(idx) < MAGIC_BYTES + FB);
  assign in_crc    = !in_magic && !in_len;
  assign magic_bad = en && in_magic && (data != magic_at(idx[1:0]));
  assign complete  = en && (int'(idx) == NBYTES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx       <= '0;
      field_len <= '0;
      field_crc <= '0;
    end else if (en && !magic_bad) begin
      idx <= idx + IW'(1);
      // Least-significant byte first: shift new bytes in from the top.
      if (in_len) field_len <= {data, field_len[FIELD_W-1:8]};
      if (in_crc) field_crc <= {data, field_crc[FIELD_W-1:8]};
    end
  end

endmodule

// File: rtl/uart_image_loader.sv
module uart_image_loader
  import img_loader_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int HDR_MS = 1000,
  parameter int PAY_MS = 3000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [7:0]  pay_data,
  output logic        pay_valid,
  input  logic        pay_ready,
  output logic        done,
  output logic        crc_ok,
  output logic        crc_bad,
  output logic        load_timeout,
  output logic        sync_retry,
  output logic [31:0] pay_len,
  output logic [31:0] exp_crc,
  output logic [31:0] calc_crc
);

  localparam int TICKS_MS = CLK_HZ / 1000;
  localparam int HDR_CYC  = TICKS_MS * HDR_MS;
  localparam int PAY_CYC  = TICKS_MS * PAY_MS;
  localparam int MAX_CYC  = (HDR_CYC > PAY_CYC) ? HDR_CYC : PAY_CYC;
  localparam int TW       = $clog2(MAX_CYC + 1);

  ld_state_e   state;
  logic [1:0]  tx_idx;
  logic [31:0] remain;

  logic          rx_fire, tx_fire, send_done;
  logic          hdr_en, hdr_bad, hdr_done, hdr_abort;
  logic          pay_acc, pay_last;
  logic          tmr_load, tmr_run, tmr_exp;
  logic [TW-1:0] tmr_limit;
  logic [31:0]   crc_res;

  always_comb begin
    rx_ready = (state == ST_PAY) ? pay_ready : 1'b1;
  end

  assign pay_valid = (state == ST_PAY) && rx_valid;
  assign pay_data  = rx_data;

  assign rx_fire   = rx_valid && rx_ready;
  assign tx_fire   = tx_valid && tx_ready;
  assign send_done = (state == ST_SEND) && tx_fire && (tx_idx == 2'd3);
  assign hdr_en    = (state == ST_HDR) && rx_valid;
  assign hdr_abort = (state == ST_HDR) && (hdr_bad || (tmr_exp && !hdr_done));
  assign pay_acc   = (state == ST_PAY) && rx_fire;
  assign pay_last  = pay_acc && (remain == 32'd1);

  assign tmr_load  = send_done || ((state == ST_HDR) && hdr_done);
  assign tmr_limit = send_done ? TW'(HDR_CYC) : TW'(PAY_CYC);
  assign tmr_run   = (state == ST_HDR) || (state == ST_PAY);

  img_hdr_collect #(.FIELD_W(32)) u_hdr (
    .clk       (clk),
    .rst       (rst),
    .clear     (send_done),
    .en        (hdr_en),
    .data      (rx_data),
    .magic_bad (hdr_bad),
    .complete  (hdr_done),
    .field_len (pay_len),
    .field_crc (exp_crc)
  );

  img_phase_timer #(.CW(TW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .limit   (tmr_limit),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  img_crc32 u_crc (
    .clk    (clk),
    .rst    (rst),
    .clear  (hdr_done),
    .en     (pay_acc),
    .data   (rx_data),
    .result (crc_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      tx_valid     <= 1'b0;
      tx_data      <= '0;
      tx_idx       <= '0;
      remain       <= '0;
      done         <= 1'b0;
      crc_ok       <= 1'b0;
      crc_bad      <= 1'b0;
      load_timeout <= 1'b0;
      sync_retry   <= 1'b0;
      calc_crc     <= '0;
    end else begin
      sync_retry <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state        <= ST_SEND;
            tx_valid     <= 1'b1;
            tx_data      <= magic_at(2'd0);
            tx_idx       <= '0;
            done         <= 1'b0;
            crc_ok       <= 1'b0;
            crc_bad      <= 1'b0;
            load_timeout <= 1'b0;
            calc_crc     <= '0;
          end
        end
        ST_SEND: begin
          if (tx_fire) begin
            if (tx_idx == 2'd3) begin
              tx_valid <= 1'b0;
              state    <= ST_HDR;
            end else begin
              tx_idx  <= tx_idx + 2'd1;
              tx_data <= magic_at(tx_idx + 2'd1);
            end
          end
        end
        ST_HDR: begin
          if (hdr_abort) begin
            sync_retry <= 1'b1;
            state      <= ST_SEND;
            tx_valid   <= 1'b1;
            tx_data    <= magic_at(2'd0);
            tx_idx     <= '0;
          end else if (hdr_done) begin
            remain <= pay_len;
            state  <= (pay_len == 32'd0) ? ST_CHECK : ST_PAY;
          end
        end
        ST_PAY: begin
          if (pay_acc) remain <= remain - 32'd1;
          if (pay_last) begin
            state <= ST_CHECK;
          end else if (tmr_exp) begin
            state        <= ST_DONE;
            load_timeout <= 1'b1;
            done         <= 1'b1;
            calc_crc     <= crc_res;
          end
        end
        ST_CHECK: begin
          calc_crc <= crc_res;
          crc_ok   <= (crc_res == exp_crc);
          crc_bad  <= (crc_res != exp_crc);
          done     <= 1'b1;
          state    <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/img_loader_chk.sv
module img_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        rx_ready,
  input logic        pay_valid,
  input logic        pay_ready,
  input logic        done,
  input logic        crc_ok,
  input logic        crc_bad,
  input logic        load_timeout,
  input logic        sync_retry,
  input logic [31:0] exp_crc,
  input logic [31:0] calc_crc
);

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R2
  no_pay_in_greeting_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid |-> !tx_valid);

  // R3
  retry_restart_chk: assert property (@(posedge clk) disable iff (rst)
    sync_retry |-> tx_valid && (tx_data == 8'h46));

  // R3
  retry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sync_retry |=> !sync_retry);

  // R6
  pay_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid && !pay_ready |-> !rx_ready);

  // R7
  crc_ok_match_chk: assert property (@(posedge clk) disable iff (rst)
    crc_ok |-> calc_crc == exp_crc);

  // R7
  crc_bad_match_chk: assert property (@(posedge clk) disable iff (rst)
    crc_bad |-> calc_crc != exp_crc);

  // R11
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({crc_ok, crc_bad, load_timeout}) == (done ? 1 : 0));

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

endmodule

bind uart_image_loader img_loader_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .tx_data      (tx_data),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .rx_ready     (rx_ready),
  .pay_valid    (pay_valid),
  .pay_ready    (pay_ready),
  .done         (done),
  .crc_ok       (crc_ok),
  .crc_bad      (crc_bad),
  .load_timeout (load_timeout),
  .sync_retry   (sync_retry),
  .exp_crc      (exp_crc),
  .calc_crc     (calc_crc)
);

// File: tb/tb_uart_image_loader.sv
`timescale 1ns/1ps
module tb_uart_image_loader;

  localparam int HDR_N = 5000;   // 5 cycles per ms * 1000 ms
  localparam int PAY_N = 15000;  // 5 cycles per ms * 3000 ms

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  pay_data;
  logic        pay_valid;
  logic        pay_ready = 1'b1;
  logic        done, crc_ok, crc_bad, load_timeout, sync_retry;
  logic [31:0] pay_len, exp_crc, calc_crc;

  always #4 clk = ~clk;

  uart_image_loader #(.CLK_HZ(5000), .HDR_MS(1000), .PAY_MS(3000)) dut (
    .clk(clk), .rst(rst), .start(start),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .done(done), .crc_ok(crc_ok), .crc_bad(crc_bad),
    .load_timeout(load_timeout), .sync_retry(sync_retry),
    .pay_len(pay_len), .exp_crc(exp_crc), .calc_crc(calc_crc)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int retries = 0;
  int ncap = 0;
  int last_acc = 0;
  int hs_edge = 0;
  logic [7:0] pl  [0:63];
  logic [7:0] cap [0:63];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && sync_retry) retries++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, pl[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0; pay_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ncap = 0; retries = 0;
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic hs_collect(output logic [31:0] word);
    int n = 0;
    int guard = 0;
    word = '0;
    tx_ready = 1'b1;
    while (n < 4 && guard < 100) begin
      #1;
      if (tx_valid) begin
        word = {word[23:0], tx_data};
        hs_edge = cyc + 1;
        n++;
      end
      @(negedge clk);
      guard++;
    end
    tx_ready = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    int guard = 0;
    rx_data = b; rx_valid = 1'b1;
    #1;
    while (!rx_ready && guard < 1000) begin
      @(negedge clk); #1; guard++;
    end
    if (pay_valid) begin
      cap[ncap] = pay_data;
      ncap++;
    end
    last_acc = cyc + 1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [31:0] len, input logic [31:0] crc);
    rx_byte(8'h46); rx_byte(8'h47); rx_byte(8'h50); rx_byte(8'h41);
    for (int i = 0; i < 4; i++) rx_byte(len[8*i +: 8]);
    for (int i = 0; i < 4; i++) rx_byte(crc[8*i +: 8]);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < PAY_N + 100) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) pl[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
  endtask

  task automatic open_session();
    logic [31:0] w;
    do_start();
    hs_collect(w);
    chk(w == 32'h46475041, "R1 greeting bytes", w, 32'h46475041);
  endtask

  task automatic check_cap(input int n, input string req);
    bit same = (ncap == n);
    for (int i = 0; i < n && i < ncap; i++) if (cap[i] !== pl[i]) same = 0;
    chk(same, req, 32'(ncap), 32'(n));
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(!tx_valid && !done && !crc_ok && !crc_bad && !load_timeout && !sync_retry,
        "R11 reset outputs low", {26'd0, tx_valid, done, crc_ok, crc_bad, load_timeout, sync_retry}, 32'd0);
  endtask

  task automatic t_known_vector();
    logic [7:0] s [0:8] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    do_reset();
    for (int i = 0; i < 9; i++) pl[i] = s[i];
    open_session();
    send_hdr(32'd9, 32'hCBF43926);
    chk(pay_len == 32'd9, "R4 length LSB first", pay_len, 32'd9);
    chk(exp_crc == 32'hCBF43926, "R4 crc field LSB first", exp_crc, 32'hCBF43926);
    for (int i = 0; i < 9; i++) rx_byte(pl[i]);
    wait_done();
    chk(crc_ok && !crc_bad, "R7 known vector verdict", {30'd0, crc_ok, crc_bad}, 32'd2);
    chk(calc_crc == 32'hCBF43926, "R7 known vector crc", calc_crc, 32'hCBF43926);
    rx_byte(8'hAA);
    check_cap(9, "R6 exact payload forwarded");
    chk(done && crc_ok, "R11 verdict held", {30'd0, done, crc_ok}, 32'd3);
  endtask

  task automatic t_crc_bad();
    logic [31:0] r;
    do_reset();
    fill(20, 3);
    r = ref_crc(20);
    open_session();
    send_hdr(32'd20, r ^ 32'h1);
    for (int i = 0; i < 20; i++) rx_byte(pl[i]);
    wait_done();
    chk(crc_bad && !crc_ok && done, "R7 mismatch flagged", {29'd0, done, crc_ok, crc_bad}, 32'd5);
    chk(calc_crc == r, "R7 computed crc exposed", calc_crc, r);
    chk(exp_crc == (r ^ 32'h1), "R7 expected crc exposed", exp_crc, r ^ 32'h1);
  endtask

  task automatic t_magic_retry();
    logic [31:0] w;
    do_reset();
    fill(3, 7);
    open_session();
    rx_byte(8'h46); rx_byte(8'h58);
    @(negedge clk);
    chk(retries == 1, "R3 retry pulse on bad echo", 32'(retries), 32'd1);
    hs_collect(w);
    chk(w == 32'h46475041, "R3 greeting resent", w, 32'h46475041);
    send_hdr(32'd3, ref_crc(3));
    for (int i = 0; i < 3; i++) rx_byte(pl[i]);
    wait_done();
    chk(crc_ok, "R3 session after retry", {31'd0, crc_ok}, 32'd1);
  endtask

  task automatic t_pre_greeting();
    logic [31:0] w;
    bit leak = 0;
    do_reset();
    fill(4, 9);
    do_start();
    for (int i = 0; i < 3; i++) begin
      rx_data = 8'h46 + 8'(i); rx_valid = 1'b1; #1;
      if (!rx_ready || pay_valid) leak = 1;
      @(negedge clk);
    end
    rx_valid = 1'b0;
    chk(!leak, "R2 early bytes consumed silently", {31'd0, leak}, 32'd0);
    chk(tx_valid && tx_data == 8'h46, "R1 byte held while stalled", {24'd0, tx_data}, 32'h46);
    hs_collect(w);
    send_hdr(32'd4, ref_crc(4));
    for (int i = 0; i < 4; i++) rx_byte(pl[i]);
    wait_done();
    chk(crc_ok && retries == 0 && ncap == 4, "R2 header unaffected by early bytes",
        32'(retries), 32'd0);
  endtask

  task automatic t_stall();
    bit bad = 0;
    do_reset();
    fill(8, 2);
    open_session();
    send_hdr(32'd8, ref_crc(8));
    for (int i = 0; i < 4; i++) rx_byte(pl[i]);
    pay_ready = 1'b0;
    rx_data = pl[4]; rx_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1; if (rx_ready || !pay_valid) bad = 1;
      @(negedge clk);
    end
    rx_valid = 1'b0;
    pay_ready = 1'b1;
    chk(!bad, "R6 stall holds rx_ready low", {31'd0, bad}, 32'd0);
    for (int i = 4; i < 8; i++) rx_byte(pl[i]);
    wait_done();
    check_cap(8, "R6 no byte lost under stall");
    chk(crc_ok, "R6 crc after stall", calc_crc, ref_crc(8));
  endtask

  task automatic t_zero_len();
    do_reset();
    open_session();
    send_hdr(32'd0, 32'd0);
    repeat (2) @(negedge clk);
    chk(done && crc_ok, "R8 zero length verdict", {30'd0, done, crc_ok}, 32'd3);
    chk(calc_crc == 32'd0, "R8 empty crc", calc_crc, 32'd0);
    chk(ncap == 0, "R8 nothing forwarded", 32'(ncap), 32'd0);
  endtask

  task automatic t_hdr_timeout();
    do_reset();
    open_session();
    rx_byte(8'h46); rx_byte(8'h47);
    wait_cyc(hs_edge + HDR_N - 1);
    chk(!tx_valid && retries == 0, "R5 no retry before header deadline", {31'd0, tx_valid}, 32'd0);
    @(negedge clk);
    chk(tx_valid && sync_retry, "R5 retry at header deadline", {30'd0, tx_valid, sync_retry}, 32'd3);
  endtask

  task automatic t_pay_timeout();
    int h;
    do_reset();
    fill(5, 4);
    open_session();
    send_hdr(32'd5, ref_crc(5));
    h = last_acc;
    rx_byte(pl[0]); rx_byte(pl[1]);
    wait_cyc(h + PAY_N - 1);
    chk(!done, "R9 no timeout before deadline", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(done && load_timeout && !crc_ok && !crc_bad, "R9 timeout at deadline",
        {28'd0, done, load_timeout, crc_ok, crc_bad}, 32'd12);
  endtask

  task automatic t_race(input bit late);
    int h;
    do_reset();
    fill(3, 6);
    open_session();
    send_hdr(32'd3, ref_crc(3));
    h = last_acc;
    rx_byte(pl[0]); rx_byte(pl[1]);
    wait_cyc(h + PAY_N - 1 + (late ? 1 : 0));
    rx_byte(pl[2]);
    wait_done();
    if (!late) begin
      chk(last_acc == h + PAY_N, "R10 byte on deadline edge", 32'(last_acc), 32'(h + PAY_N));
      chk(crc_ok && !load_timeout, "R10 byte wins over deadline", {30'd0, crc_ok, load_timeout}, 32'd2);
      check_cap(3, "R10 last byte forwarded");
    end else begin
      chk(load_timeout && !crc_ok, "R10 late byte loses", {30'd0, crc_ok, load_timeout}, 32'd1);
      chk(ncap == 2, "R10 late byte dropped", 32'(ncap), 32'd2);
    end
  endtask

  initial begin
    t_reset();
    t_known_vector();
    t_crc_bad();
    t_magic_retry();
    t_pre_greeting();
    t_stall();
    t_zero_len();
    t_hdr_timeout();
    t_pay_timeout();
    t_race(1'b0);
    t_race(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule